// File: doc/BRIEF.md
# Boundary Signature and Pattern Engine

This block carries out the self-test operations that run on an eight-lane boundary while the test access port dwells in its idle state. A two-bit control register picks one of four operations. Parallel signature analysis folds the captured lane inputs into a running signature. Pattern generation drives a pseudo-random sequence onto the lane outputs. Sample-and-toggle copies the inputs and inverts the output pattern. The fourth code holds both registers.

The block runs on the test clock. An operation advances only on rising edges where the external controller reports the idle state (`run_idle`) and a test-mode instruction is in force (`test_mode`). The control register is loaded serially, like any data register. It shifts on rising edges while selected and in the shift state, and its parallel stage is updated on the falling edge during the update state. The access-port state machine sits outside this block.

Top module: `bsp_engine`

## Requirements
- R1: While `rst_n` is low, `sig_out` and `pat_out` are all zeros. Both the control shift stage and the mode register reset to code 10 (signature analysis). Bit 0 of the shift stage appears on `ctl_tdo`, so `ctl_tdo` reads 0 after reset and reads 1 after one shift.
- R2: On a rising edge where `run_idle` and `test_mode` are not both high, `sig_out` and `pat_out` keep their values.
- R3: With mode code 10 and the block active, each rising edge loads `sig_out` with step(sig) XOR `din`. step(s) = {s[6:0], s[7]^s[3]^s[2]^s[1]}, which is the polynomial x^8+x^4+x^3+x^2+1. `pat_out` holds.
- R4: With mode code 01 and the block active, each rising edge loads `pat_out` with 00000001 if it was all zeros, and with step(pat_out) otherwise. `sig_out` holds. Starting from 00000001, the sequence returns to 00000001 after exactly 255 steps.
- R5: With mode code 00 and the block active, each rising edge loads `sig_out` with `din` and `pat_out` with the bitwise inverse of its previous value.
- R6: With mode code 11 and the block active, both `sig_out` and `pat_out` hold.
- R7: On a rising edge with `ctl_sel` and `ctl_shift` both high, the shift stage moves right: `ctl_tdi` enters bit 1 and bit 1 moves to bit 0. At all other times the stage, and therefore `ctl_tdo`, holds.
- R8: On a falling edge with `ctl_sel` and `ctl_update` both high, the mode register takes the shift stage. The new code governs from the next rising edge, including the rising edge that closes the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_idle | input | 1 | High while the controller is in its idle state |
| test_mode | input | 1 | High while a test-mode instruction is active |
| din | input | 8 | Captured lane inputs |
| ctl_sel | input | 1 | Control register is the selected data register |
| ctl_shift | input | 1 | Controller is in the data shift state |
| ctl_update | input | 1 | Controller is in the data update state |
| ctl_tdi | input | 1 | Serial data into the control register |
| ctl_tdo | output | 1 | Serial data out of the control register |
| pat_out | output | 8 | Test output pattern |
| sig_out | output | 8 | Signature or sample register, for scan-out |

## Verification
The bench builds the block at its default eight-lane width with the default feedback taps. At that size the whole 255-state pattern cycle can be walked in one directed run, so both the period and the escape from the all-zero state are checked exactly. Random mode codes, gating and serial loads, including updates that land in an active cycle, exercise every operation and the falling-edge timing against a bench model written from the requirements.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int unsigned CTL_W = 2;

  typedef enum logic [CTL_W-1:0] {
    MODE_TOG  = 2'b00,
    MODE_PRPG = 2'b01,
    MODE_PSA  = 2'b10,
    MODE_HOLD = 2'b11
  } bsp_mode_e;

  localparam bsp_mode_e MODE_RST = MODE_PSA;
endpackage

// File: rtl/bsp_ctl_reg.sv
module bsp_ctl_reg
  import bsp_pkg::*;
(
  input  logic      tck,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      shift,
  input  logic      update,
  input  logic      tdi,
  output logic      tdo,
  output bsp_mode_e mode,
  output logic      shift_ev,
  output logic      upd_ev
);
  logic [CTL_W-1:0] sh_q;

  assign shift_ev = sel && shift;
  assign upd_ev   = sel && update;

  // serial stage, rising edge
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        sh_q <= MODE_RST;
    else if (shift_ev) sh_q <= {tdi, sh_q[CTL_W-1:1]};
  end

  // parallel stage, falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      mode <= MODE_RST;
    else if (upd_ev) mode <= bsp_mode_e'(sh_q);
  end

  assign tdo = sh_q[0];
endmodule

// File: rtl/bsp_lfsr_next.sv
module bsp_lfsr_next #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'b1000_1110
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] inject,
  output logic [W-1:0] nxt
);
  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    logic fb;
    fb = ^(s & TAPS);
    return {s[W-2:0], fb};
  endfunction

  assign nxt = step(cur) ^ inject;
endmodule

// File: rtl/bsp_sig_unit.sv
module bsp_sig_unit #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'b1000_1110
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         psa_en,
  input  logic         smp_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig_q
);
  logic [W-1:0] comp_nxt;

  bsp_lfsr_next #(.W(W), .TAPS(TAPS)) comp_i (
    .cur(sig_q), .inject(din), .nxt(comp_nxt)
  );

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sig_q <= '0;
    else if (psa_en) sig_q <= comp_nxt;
    else if (smp_en) sig_q <= din;
  end
endmodule

// File: rtl/bsp_pat_unit.sv
module bsp_pat_unit #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'b1000_1110
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         prpg_en,
  input  logic         tog_en,
  output logic [W-1:0] pat_q,
  output logic         zero_esc
);
  localparam logic [W-1:0] SEED = W'(1);
  localparam logic [W-1:0] NONE = '0;

  logic [W-1:0] gen_nxt;

  bsp_lfsr_next #(.W(W), .TAPS(TAPS)) gen_i (
    .cur(pat_q), .inject(NONE), .nxt(gen_nxt)
  );

  assign zero_esc = prpg_en && (pat_q == '0);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        pat_q <= '0;
    else if (zero_esc) pat_q <= SEED;
    else if (prpg_en)  pat_q <= gen_nxt;
    else if (tog_en)   pat_q <= ~pat_q;
  end
endmodule

// File: rtl/bsp_engine.sv
module bsp_engine
  import bsp_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'b1000_1110
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         run_idle,
  input  logic         test_mode,
  input  logic [W-1:0] din,
  input  logic         ctl_sel,
  input  logic         ctl_shift,
  input  logic         ctl_update,
  input  logic         ctl_tdi,
  output logic         ctl_tdo,
  output logic [W-1:0] pat_out,
  output logic [W-1:0] sig_out
);
  bsp_mode_e mode;
  logic shift_ev, upd_ev, zero_esc;
  logic active, psa_en, prpg_en, tog_en;

  bsp_ctl_reg ctl_i (
    .tck(tck), .rst_n(rst_n), .sel(ctl_sel), .shift(ctl_shift),
    .update(ctl_update), .tdi(ctl_tdi), .tdo(ctl_tdo), .mode(mode),
    .shift_ev(shift_ev), .upd_ev(upd_ev)
  );

  assign active  = run_idle && test_mode;
  assign psa_en  = active && (mode == MODE_PSA);
  assign prpg_en = active && (mode == MODE_PRPG);
  assign tog_en  = active && (mode == MODE_TOG);

  bsp_sig_unit #(.W(W), .TAPS(TAPS)) sig_i (
    .tck(tck), .rst_n(rst_n), .psa_en(psa_en), .smp_en(tog_en),
    .din(din), .sig_q(sig_out)
  );

  bsp_pat_unit #(.W(W), .TAPS(TAPS)) pat_i (
    .tck(tck), .rst_n(rst_n), .prpg_en(prpg_en), .tog_en(tog_en),
    .pat_q(pat_out), .zero_esc(zero_esc)
  );
endmodule

// File: rtl/bsp_engine_chk.sv
module bsp_engine_chk
  import bsp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         tck,
  input logic         rst_n,
  input logic         active,
  input bsp_mode_e    mode,
  input logic         shift_ev,
  input logic [W-1:0] din,
  input logic         ctl_tdo,
  input logic [W-1:0] pat_out,
  input logic [W-1:0] sig_out
);
  // R1
  always @(posedge tck) begin
    if (!rst_n) begin
      reset_clear_chk: assert (sig_out == '0 && pat_out == '0);
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !active |=> ($stable(sig_out) && $stable(pat_out)));

  // R3
  psa_pat_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (active && mode == MODE_PSA) |=> $stable(pat_out));

  // R4
  prpg_nonzero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (active && mode == MODE_PRPG) |=> (pat_out != '0 && $stable(sig_out)));

  // R5
  toggle_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (active && mode == MODE_TOG) |=>
      (pat_out == ~$past(pat_out) && sig_out == $past(din)));

  // R6
  hold_mode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (active && mode == MODE_HOLD) |=> ($stable(sig_out) && $stable(pat_out)));

  // R7
  ctl_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !shift_ev |=> $stable(ctl_tdo));
endmodule

bind bsp_engine bsp_engine_chk #(.W(W)) chk_i (
  .tck(tck), .rst_n(rst_n), .active(active), .mode(mode),
  .shift_ev(shift_ev), .din(din), .ctl_tdo(ctl_tdo),
  .pat_out(pat_out), .sig_out(sig_out)
);

// File: tb/bsp_engine_tb_top.sv
`timescale 1ns/1ps
module bsp_engine_tb_top;
  localparam int W = 8;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic run_idle = 1'b0, test_mode = 1'b0;
  logic [W-1:0] din = '0;
  logic ctl_sel = 1'b0, ctl_shift = 1'b0, ctl_update = 1'b0, ctl_tdi = 1'b0;
  logic ctl_tdo;
  logic [W-1:0] pat_out, sig_out;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [1:0]   m_sh  = 2'b10;
  logic [1:0]   m_ctl = 2'b10;
  logic [W-1:0] m_sig = '0;
  logic [W-1:0] m_pat = '0;

  always #2.5 tck = ~tck;

  bsp_engine dut_i (
    .tck(tck), .rst_n(rst_n), .run_idle(run_idle), .test_mode(test_mode),
    .din(din), .ctl_sel(ctl_sel), .ctl_shift(ctl_shift),
    .ctl_update(ctl_update), .ctl_tdi(ctl_tdi), .ctl_tdo(ctl_tdo),
    .pat_out(pat_out), .sig_out(sig_out)
  );

  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
    logic t;
    t = s[7] ^ s[3] ^ s[2] ^ s[1];
    return {s[6:0], t};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic a, input logic [1:0] c);
    if (!a) return "R2";
    case (c)
      2'b10:   return "R3";
      2'b01:   return "R4";
      2'b00:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // one test-clock cycle: drive, let both edges pass, update model, compare
  task automatic cyc(input logic ri, input logic tm, input logic sel,
                     input logic sh, input logic up, input logic tdi,
                     input logic [W-1:0] d);
    logic a;
    string tg;
    run_idle = ri; test_mode = tm; ctl_sel = sel; ctl_shift = sh;
    ctl_update = up; ctl_tdi = tdi; din = d;
    @(posedge tck);
    if (sel && up) m_ctl = m_sh;                 // falling edge before
    a = ri && tm;
    tg = (sel && up) ? {"R8 ", mode_tag(a, m_ctl)} : mode_tag(a, m_ctl);
    if (a) begin
      case (m_ctl)
        2'b10: m_sig = ref_step(m_sig) ^ d;
        2'b01: m_pat = (m_pat == '0) ? 8'h01 : ref_step(m_pat);
        2'b00: begin m_sig = d; m_pat = ~m_pat; end
        default: ;
      endcase
    end
    if (sel && sh) m_sh = {tdi, m_sh[1]};
    #1;
    check(tg, sig_out, m_sig);
    check(tg, pat_out, m_pat);
    check("R7", {7'd0, ctl_tdo}, {7'd0, m_sh[0]});
  endtask

  task automatic load_mode(input logic [1:0] m);
    cyc(0, 0, 1, 1, 0, m[0], '0);
    cyc(0, 0, 1, 1, 0, m[1], '0);
    cyc(0, 0, 1, 0, 1, 0, '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge tck);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int steps;
    logic seen_early;
    void'($urandom(32'd1234));
    repeat (3) @(posedge tck);
    #1;
    // R1 reset contents
    check("R1", sig_out, '0);
    check("R1", pat_out, '0);
    check("R1", {7'd0, ctl_tdo}, 8'd0);
    rst_n = 1'b1;
    // R1 reset code 10: one shift brings bit 1 out
    cyc(0, 0, 1, 1, 0, 0, '0);
    check("R1", {7'd0, ctl_tdo}, 8'd1);
    // R3 signature with reset mode already in force
    cyc(1, 1, 0, 0, 0, 0, 8'hA5);
    cyc(1, 1, 0, 0, 0, 0, 8'h3C);
    check("R3", sig_out, ref_step(8'hA5) ^ 8'h3C);
    // R2 gated by test_mode
    cyc(1, 0, 0, 0, 0, 0, 8'hFF);
    cyc(0, 1, 0, 0, 0, 0, 8'h0F);
    // R4 escape from zero, then full period
    load_mode(2'b01);
    cyc(1, 1, 0, 0, 0, 0, 8'h77);
    check("R4", pat_out, 8'h01);
    steps = 0;
    seen_early = 1'b0;
    for (int i = 0; i < 255; i++) begin
      cyc(1, 1, 0, 0, 0, 0, 8'($urandom));
      steps++;
      if (pat_out == 8'h01 && steps < 255) seen_early = 1'b1;
    end
    check("R4", {7'd0, seen_early}, 8'd0);
    check("R4", pat_out, 8'h01);
    // R8 update in an active cycle takes effect at its closing edge
    cyc(0, 0, 1, 1, 0, 0, '0);
    cyc(0, 0, 1, 1, 0, 0, '0);
    cyc(1, 1, 1, 0, 1, 0, 8'h5A);
    check("R8", pat_out, 8'hFE);
    check("R8", sig_out, 8'h5A);
    // R6 hold code
    load_mode(2'b11);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, 0, 8'($urandom));
    check("R6", pat_out, 8'hFE);
    // R5 toggle twice returns the pattern
    load_mode(2'b00);
    cyc(1, 1, 0, 0, 0, 0, 8'h12);
    cyc(1, 1, 0, 0, 0, 0, 8'h34);
    check("R5", pat_out, 8'hFE);
    check("R5", sig_out, 8'h34);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(r[0] | r[1], r[2] | r[3], ($urandom % 4) == 0,
          ($urandom % 2) == 0, ($urandom % 3) == 0,
          1'($urandom), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule